// File: doc/BRIEF.md
# Serial Command and Status Port with Chain Pass-Through

This block is the serial slave port of a multi-channel power switch controller. A host frames a transfer with an active-low select. Each frame carries 16-bit command words, most significant bit first. While the frame runs, the port returns a 16-bit status word on its serial output. Bits clocked in after that status word are repeated on the output, so several ports can share one select line in a chain. When select rises, the port checks how many bits were clocked. If the count is a nonzero multiple of 16, it commits the last 16 bits received as a command.

A command holds a 5-bit address in bits [15:11] and an 8-bit value in bits [7:0]. Address 0 is the setup command, and its bits [1:0] choose which status word later frames return. Five addresses hold the per-output control bytes and one holds the external switch byte. Every other address, including the reserved one, is ignored. Fault inputs are sampled every cycle into sticky flags. A committed read clears the flags it reported. A fault that is still present, or that arrived after the status snapshot was taken, stays set.

The serial clock and select are sampled by the system clock. They must be slow enough for the port to see each level for at least two system clocks.

Top module: `serial_cmd_port`

## Requirements
- R1: SI and SO are shifted most significant bit first. SI is sampled on the serial clock rising edge. The first 16 SO bits are the status word chosen by the stored select code, and each SO bit is valid before the rising edge that consumes it.
- R2: On the rising edge of select, a frame is committed only if the bit count is 16, 32, 48, and so on.
- R3: A frame of any other length, including zero bits, changes no control byte and no select code, clears no fault flag, and leaves later readback as if the frame had not happened.
- R4: SO is high impedance while select is high.
- R5: After the first 16 bits of a frame, SO repeats the SI bits in the order they arrived since select fell.
- R6: In a valid frame longer than 16 bits, the last 16 bits received form the command.
- R7: Addresses 9 to 13 write the control bytes of outputs 1 to 5, and address 14 writes the external switch byte. Address 15, and any address other than 0 and 9 to 14, changes nothing.
- R8: Address 0 stores bits [1:0] as the select code, which takes effect from the next frame on. The frame carrying the command still returns the previous selection. The codes are:
  - 0: overcurrent word.
  - 1: overtemperature word.
  - 2: {output 2 byte, output 1 byte}.
  - 3: {output 4 byte, output 3 byte}.
- R9: In the select 0 and select 1 words, bit 13 is the sticky under-voltage flag and bit 10 is the live normal-mode input. Bits [4:0] are the sticky overcurrent (code 0) or overtemperature (code 1) flags of outputs 1 to 5. All other bits are 0.
- R10: A committed frame clears the sticky flags shown in its own status word. A flag whose input is still active stays set. A fault that arrives after select fell is kept for the next read.
- R11: The bit counter saturates at 127. A frame of 128 bits or more is rejected, while a 112-bit frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high impedance when deselected |
| ocIn | input | 5 | Overcurrent fault inputs, outputs 1 to 5 |
| otIn | input | 5 | Overtemperature fault inputs, outputs 1 to 5 |
| uvfIn | input | 1 | Under-voltage fault input |
| nmIn | input | 1 | Normal-mode indication |
| ctrlOut | output | 48 | Control bytes; output k at [8(k-1)+:8], external switch at [47:40] |

## Verification
The assertions assume three things about the inputs:
- sclk, csN and si are synchronous to clk.
- Each sclk and csN level lasts at least two system clocks.
- sclk is low whenever csN changes.

The bench drives every input on the falling edge of clk and holds each serial clock phase for several clocks, so edge detection never sees a glitch. Each SO bit is sampled just before the rising serial edge that would consume it. Fault pulses are injected at known points inside or between frames, so each sticky flag's expected state is known.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int WORD_W = 16;
  localparam int LOG_W = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int SEL_W = 2;
  localparam int ADDR_SETUP = 0;
  localparam int ADDR_OUT_BASE = 9;
  localparam int UVF_BIT = 13;
  localparam int NM_BIT = 10;

  typedef struct packed {
    logic loadTx;
    logic shiftEn;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/serial_cmd_ctrl.sv
module serial_cmd_ctrl
  import serial_cmd_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  output strobe_t strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic csQ, sclkQ;
  logic [CNT_W-1:0] bitCnt;
  logic csFall, csRise, sclkRise, lenOk;

  assign csFall = csQ & ~csN;
  assign csRise = ~csQ & csN;
  assign sclkRise = sclk & ~sclkQ & ~csN & ~csQ;
  assign lenOk = (bitCnt != '0) && (bitCnt[LOG_W-1:0] == '0) && (bitCnt != CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ <= 1'b1;
      sclkQ <= 1'b0;
      bitCnt <= '0;
    end else begin
      csQ <= csN;
      sclkQ <= sclk;
      if (csFall) bitCnt <= '0;
      else if (sclkRise && bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.loadTx = csFall;
    strb.shiftEn = sclkRise;
    strb.commit = csRise & lenOk;
  end

  // R11: a saturated counter holds until the next frame starts
  p_cnt_saturate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == CNT_MAX && !csFall) |=> bitCnt == CNT_MAX);

  // R2: every frame starts counting from zero
  p_cnt_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    csFall |=> bitCnt == '0);

  // R3: no commit while a frame is still open
  p_no_commit_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !strb.commit);
endmodule

// File: rtl/serial_cmd_datapath.sv
module serial_cmd_datapath
  import serial_cmd_pkg::*;
#(
  parameter int NUM_OUT = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic                          si,
  input  logic [NUM_OUT-1:0]            ocIn,
  input  logic [NUM_OUT-1:0]            otIn,
  input  logic                          uvfIn,
  input  logic                          nmIn,
  output logic                          txBit,
  output logic [(NUM_OUT+1)*DATA_W-1:0] ctrlFlat
);
  localparam int NUM_REG = NUM_OUT + 1;

  logic [WORD_W-1:0] shiftReg;
  logic [SEL_W-1:0] selQ;
  logic [NUM_OUT-1:0] ocL, otL, rdOc, rdOt;
  logic uvfL, rdUvf;
  logic [DATA_W-1:0] ctrlReg [NUM_REG];
  logic [WORD_W-1:0] statOc, statOt, statLo, statHi, statSel;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;

  assign cmdAddr = shiftReg[WORD_W-1 -: ADDR_W];
  assign cmdData = shiftReg[DATA_W-1:0];
  assign txBit = shiftReg[WORD_W-1];

  always_comb begin
    statOc = '0;
    statOc[UVF_BIT] = uvfL;
    statOc[NM_BIT] = nmIn;
    statOt = statOc;
    statOc[NUM_OUT-1:0] = ocL;
    statOt[NUM_OUT-1:0] = otL;
    statLo = {ctrlReg[1], ctrlReg[0]};
    statHi = {ctrlReg[3], ctrlReg[2]};
    case (selQ)
      2'd0: statSel = statOc;
      2'd1: statSel = statOt;
      2'd2: statSel = statLo;
      default: statSel = statHi;
    endcase
  end

  // serial shift register: status out, command in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.loadTx) shiftReg <= statSel;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], si};
  end

  // snapshot of flags shown in the current status word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdOc <= '0;
      rdOt <= '0;
      rdUvf <= 1'b0;
    end else if (strb.loadTx) begin
      rdOc <= (selQ == 2'd0) ? ocL : '0;
      rdOt <= (selQ == 2'd1) ? otL : '0;
      rdUvf <= (selQ <= 2'd1) ? uvfL : 1'b0;
    end
  end

  // sticky fault flags, cleared by a committed read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocL <= '0;
      otL <= '0;
      uvfL <= 1'b0;
    end else if (strb.commit) begin
      ocL <= (ocL & ~rdOc) | ocIn;
      otL <= (otL & ~rdOt) | otIn;
      uvfL <= (uvfL & ~rdUvf) | uvfIn;
    end else begin
      ocL <= ocL | ocIn;
      otL <= otL | otIn;
      uvfL <= uvfL | uvfIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selQ <= '0;
    else if (strb.commit && cmdAddr == ADDR_W'(ADDR_SETUP)) selQ <= shiftReg[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctrlReg[i] <= '0;
      else if (strb.commit && cmdAddr == ADDR_W'(ADDR_OUT_BASE + i)) ctrlReg[i] <= cmdData;
    end
    assign ctrlFlat[i*DATA_W +: DATA_W] = ctrlReg[i];

    // R3: control bytes only move on a committed frame
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !strb.commit |=> $stable(ctrlReg[i]));
  end

  // R8: select code only moves on a committed frame
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(selQ));

  // R10: an active fault input is always reflected one cycle later
  p_oc_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((ocL & $past(ocIn)) == $past(ocIn)));

  // R10: outside a commit no flag drops
  p_ot_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ((otL & $past(otL)) == $past(otL)));
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import serial_cmd_pkg::*;
#(
  parameter int NUM_OUT = 5,
  parameter int CNT_W = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          si,
  output logic                          so,
  input  logic [NUM_OUT-1:0]            ocIn,
  input  logic [NUM_OUT-1:0]            otIn,
  input  logic                          uvfIn,
  input  logic                          nmIn,
  output logic [(NUM_OUT+1)*DATA_W-1:0] ctrlOut
);
  strobe_t strb;
  logic txBit;

  serial_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .strb(strb)
  );

  serial_cmd_datapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .si(si),
    .ocIn(ocIn), .otIn(otIn), .uvfIn(uvfIn), .nmIn(nmIn),
    .txBit(txBit), .ctrlFlat(ctrlOut)
  );

  assign so = csN ? 1'bz : txBit;

  // R1: loading and shifting never coincide
  p_load_shift_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadTx && strb.shiftEn));
endmodule

// File: tb/sim_serial_cmd_port.sv
module sim_serial_cmd_port;
  logic clk = 0, rstN = 0, csN = 1, sclk = 0, si = 0, uvfIn = 0, nmIn = 0;
  logic [4:0] ocIn = 0, otIn = 0;
  logic so;
  logic [47:0] ctrlOut;
  int checks = 0, fails = 0;
  logic [7:0] expCtrl [6];
  logic [1:0] expSel = 0;
  logic [127:0] rx;
  logic [15:0] w;

  always #5 clk = ~clk;

  serial_cmd_port u0 (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .so(so),
    .ocIn(ocIn), .otIn(otIn), .uvfIn(uvfIn), .nmIn(nmIn), .ctrlOut(ctrlOut));

  initial begin
    repeat (300000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    @(negedge clk); csN = 0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      si = din[i];
      repeat (2) @(negedge clk);
      dout[i] = so;
      sclk = 1;
      repeat (3) @(negedge clk);
      sclk = 0;
      repeat (2) @(negedge clk);
    end
    csN = 1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] cmd(input int addr, input logic [7:0] d);
    return {addr[4:0], 3'b000, d};
  endfunction

  function automatic logic [47:0] expFlat();
    logic [47:0] f;
    for (int i = 0; i < 6; i++) f[i*8 +: 8] = expCtrl[i];
    return f;
  endfunction

  task automatic pulseOc(input logic [4:0] m);
    @(negedge clk); ocIn = m; @(negedge clk); ocIn = 0;
  endtask

  initial begin
    logic [127:0] r2;
    for (int i = 0; i < 6; i++) expCtrl[i] = 0;
    repeat (3) @(negedge clk); rstN = 1; repeat (2) @(negedge clk);

    chk("R4 reset ctrl", ctrlOut, 0);
    chk("R4 so idle z", {63'd0, so === 1'bz}, 1);

    // R7: write each control register
    for (int i = 0; i < 6; i++) begin
      expCtrl[i] = 8'(i * 37 + 5);
      xfer(16, cmd(9 + i, expCtrl[i]), rx);
      chk("R7 write ctrl", ctrlOut, expFlat());
    end
    xfer(16, cmd(15, 8'hFF), rx);
    chk("R7 reserved ignored", ctrlOut, expFlat());
    xfer(16, cmd(7, 8'hAA), rx);
    chk("R7 unused addr ignored", ctrlOut, expFlat());
    chk("R4 so z after frames", {63'd0, so === 1'bz}, 1);

    // R8: setup command selects readback for later frames
    nmIn = 1;
    xfer(16, cmd(0, 8'h02), rx);
    chk("R8 setup frame returns old select", rx[15:0], 16'h0400);
    xfer(16, cmd(0, 8'h03), rx);
    chk("R8 select 2 word", rx[15:0], {expCtrl[1], expCtrl[0]});
    xfer(16, cmd(15, 0), rx);
    chk("R8 select 3 word R1", rx[15:0], {expCtrl[3], expCtrl[2]});

    // R2 R3: length sweep
    for (int len = 0; len <= 48; len++) begin
      logic [7:0] v = 8'(len + 100);
      xfer(len, {112'd0, cmd(9, v)}, rx);
      if (len != 0 && len % 16 == 0) begin
        expCtrl[0] = v;
        chk("R2 valid length commits", ctrlOut, expFlat());
      end else
        chk("R3 bad length ignored", ctrlOut, expFlat());
    end
    xfer(15, {112'd0, cmd(0, 8'h00)}, rx);
    xfer(16, cmd(15, 0), rx);
    chk("R3 bad setup keeps select", rx[15:0], {expCtrl[3], expCtrl[2]});

    // R5 R6: chained 32-bit frame
    w = cmd(10, 8'h5A);
    xfer(32, {96'd0, 16'hC3A5, w}, rx);
    chk("R5 echo of first word", rx[15:0], 16'hC3A5);
    chk("R1 status first", rx[31:16], {expCtrl[3], expCtrl[2]});
    expCtrl[1] = 8'h5A;
    chk("R6 last word commits", ctrlOut, expFlat());
    xfer(48, {80'd0, 16'h1234, 16'hBEEF, cmd(15, 0)}, rx);
    chk("R5 echo 48-bit", rx[31:0], 32'h1234BEEF);

    // R9 R10: fault words
    xfer(16, cmd(0, 8'h00), rx);
    uvfIn = 1; pulseOc(5'b00100); @(negedge clk); uvfIn = 0;
    xfer(16, cmd(15, 0), rx);
    chk("R9 overcurrent word", rx[15:0], 16'h2404);
    xfer(16, cmd(15, 0), rx);
    chk("R10 cleared after read", rx[15:0], 16'h0400);
    uvfIn = 1;
    xfer(16, cmd(15, 0), rx);
    xfer(16, cmd(15, 0), rx);
    chk("R10 active fault stays", rx[15:0], 16'h2400);
    uvfIn = 0; nmIn = 0;
    xfer(16, cmd(15, 0), rx);
    fork
      xfer(16, cmd(15, 0), rx);
      begin repeat (40) @(negedge clk); pulseOc(5'b00001); end
    join
    chk("R10 late fault not in snapshot", rx[15:0], 16'h0000);
    xfer(16, cmd(15, 0), rx);
    chk("R10 late fault kept", rx[15:0], 16'h0001);
    pulseOc(5'b01000);
    xfer(8, 0, rx);
    xfer(16, cmd(15, 0), rx);
    chk("R3 bad frame no clear", rx[15:0], 16'h0008);
    // overtemperature word
    xfer(16, cmd(0, 8'h01), rx);
    @(negedge clk); otIn = 5'b10010; @(negedge clk); otIn = 0;
    xfer(16, cmd(15, 0), rx);
    chk("R9 overtemp word", rx[15:0], 16'h0012);
    xfer(16, cmd(15, 0), rx);
    chk("R10 overtemp cleared", rx[15:0], 16'h0000);

    // R11: counter saturation
    xfer(128, {112'd0, cmd(11, 8'h77)}, r2);
    chk("R11 128-bit frame rejected", ctrlOut, expFlat());
    xfer(112, {96'd0, cmd(11, 8'h66)}, r2);
    expCtrl[2] = 8'h66;
    chk("R11 112-bit frame accepted", ctrlOut, expFlat());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule